// File: doc/BRIEF.md
# Flash Command Register Interface

This block sits between an asynchronous byte-wide memory bus and a small internal byte array. It models the command layer of an electrically erasable, byte-programmable flash device. The host drives chip select, write strobe, output strobe, an address and a data byte. A program-supply flag tells the block whether erase and program operations may run. A system clock samples the write strobe through a synchronizer, and a state machine interprets each completed bus write as a command or as command data. Bus reads return array bytes, the two identifier codes, or verify data, depending on the current mode.

Erase and program are modelled as fixed busy windows. Erase clears every byte to FFh. Program ANDs the new byte into the addressed cell, so a program operation can only clear bits. Both destructive operations need two bus writes: a setup code followed by a confirming write. The address of a write is taken at the start of the strobe and its data at the end.

States: `ST_ARRAY` (array read), `ST_IDENT` (identifier read), `ST_ERASE_ARM` (erase setup waiting for confirmation), `ST_ERASE_RUN` (erase busy), `ST_ERASE_CHK` (erase verify), `ST_PROG_ARM` (program setup waiting for address and data), `ST_PROG_RUN` (program busy), `ST_PROG_CHK` (program verify), `ST_RESET_ARM` (first reset code seen). Transitions:
- From any command state (`ST_ARRAY`, `ST_IDENT`, `ST_ERASE_CHK`, `ST_PROG_CHK`), a write of 00h goes to `ST_ARRAY`, 90h to `ST_IDENT`, A0h to `ST_ERASE_CHK`, C0h to `ST_PROG_CHK`, FFh to `ST_RESET_ARM`, 20h to `ST_ERASE_ARM` and 40h to `ST_PROG_ARM`. The last two apply only when the supply flag is high. Any other code leaves the state unchanged.
- `ST_ERASE_ARM` goes to `ST_ERASE_RUN` on a confirming 20h while the supply flag is high, and to `ST_ARRAY` otherwise.
- `ST_PROG_ARM` goes to `ST_PROG_RUN` on the next write while the supply flag is high, and to `ST_ARRAY` otherwise.
- `ST_RESET_ARM` goes to `ST_ARRAY` on the next write.
- Each busy state goes to `ST_ARRAY` when its counter expires.
- A rising edge of the supply flag moves any non-busy state to `ST_ARRAY`.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset, and after a rising edge of `vpp_ok` while not busy, the block is in array read mode with `busy` low. `dout` is 00h whenever a read was not active in the previous clock cycle.
- R2: A write of 00h selects array read. A read, meaning `ce_n` and `oe_n` both low, returns the byte stored at `addr` in `dout` one clock cycle later.
- R3: A write of 90h selects identifier mode. Reads at address 0 return 89h, reads at address 1 return BDh, and reads at any other address return 00h.
- R4: Erase needs 20h followed by a second 20h. If the second write carries any other value, the block returns to array read and the array is unchanged.
- R5: A confirmed erase holds `busy` high for exactly ERASE_CYCLES clock cycles and then leaves every byte at FFh.
- R6: A write of A0h selects erase verify. Every following read returns the byte at the address of that A0h write, whatever the value of `addr`.
- R7: A write of 40h arms programming. The next write starts a program operation that holds `busy` high for exactly PROG_CYCLES cycles and then stores (old byte AND new byte) at the target address.
- R8: The address of a bus write is captured when the strobe becomes active (`ce_n` and `we_n` both low), and its data is captured when the strobe ends.
- R9: A write of C0h selects program verify. Reads return the byte at the address of the most recent program operation.
- R10: Two consecutive writes of FFh return the block to array read from any command mode.
- R11: Bus writes that complete while `busy` is high have no effect on mode or array.
- R12: While `vpp_ok` is low, writes of 20h and 40h are ignored, no busy window starts, and the array stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vpp_ok | input | 1 | Program supply present; enables erase and program |
| ce_n | input | 1 | Active-low chip select |
| we_n | input | 1 | Active-low write strobe, asynchronous to `clk` |
| oe_n | input | 1 | Active-low output strobe |
| addr | input | AW | Byte address |
| din | input | 8 | Write data byte |
| dout | output | 8 | Registered read data, 00h when no read is active |
| busy | output | 1 | High during an erase or program window |

## Verification
Programming is tried with a write whose address changes between the start and the end of the strobe and whose data changes in the same interval. This shows whether each value is taken at the correct edge. A second program to the same cell with a partly overlapping byte separates an AND merge from a plain overwrite. Erase is tried with a correct confirmation, a wrong one and a missing supply, which separates a real start from a spurious one. Verify reads use an `addr` different from the latched address, so that a verify mode cannot pass by returning the array byte at the current address. A mode command issued during a busy window checks that writes are dropped while busy.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    typedef enum logic [3:0] {
        ST_ARRAY,
        ST_IDENT,
        ST_ERASE_ARM,
        ST_ERASE_RUN,
        ST_ERASE_CHK,
        ST_PROG_ARM,
        ST_PROG_RUN,
        ST_PROG_CHK,
        ST_RESET_ARM
    } fstate_t;

    localparam logic [7:0] OP_READ      = 8'h00;
    localparam logic [7:0] OP_IDENT     = 8'h90;
    localparam logic [7:0] OP_ERASE     = 8'h20;
    localparam logic [7:0] OP_ERASE_CHK = 8'hA0;
    localparam logic [7:0] OP_PROG      = 8'h40;
    localparam logic [7:0] OP_PROG_CHK  = 8'hC0;
    localparam logic [7:0] OP_RESET     = 8'hFF;

    localparam logic [7:0] ID_MAKER = 8'h89;
    localparam logic [7:0] ID_PART  = 8'hBD;

endpackage

// File: rtl/flash_wr_sync.sv
module flash_wr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_in,
    output logic wr_start,
    output logic wr_end
);

    // STAGES synchronizer flops plus one history flop for edge detection
    logic [STAGES:0] shreg;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
        end else begin
            shreg <= {shreg[STAGES-1:0], strobe_in};
        end
    end

    logic synced;
    logic prev;

    always_comb begin
        synced   = shreg[STAGES-1];
        prev     = shreg[STAGES];
        wr_start = synced & ~prev;
        wr_end   = ~synced & prev;
    end

endmodule

// File: rtl/flash_byte_array.sv
module flash_byte_array #(
    parameter int AW = 4,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          erase_go,
    input  logic          prog_go,
    input  logic [AW-1:0] prog_addr,
    input  logic [DW-1:0] prog_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (!rst_n || erase_go) begin
                cells[i] <= '1;
            end else if (prog_go && (prog_addr == AW'(i))) begin
                cells[i] <= cells[i] & prog_data;
            end
        end
    end

    assign rd_data = cells[rd_addr];

endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
    import flash_cmd_pkg::*;
#(
    parameter int AW           = 4,
    parameter int ERASE_CYCLES = 64,
    parameter int PROG_CYCLES  = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          vpp_ok,
    input  logic          wr_start,
    input  logic          wr_end,
    input  logic [AW-1:0] bus_addr,
    input  logic [7:0]    bus_data,
    output fstate_t       state,
    output logic          busy,
    output logic          erase_go,
    output logic          prog_go,
    output logic [AW-1:0] prog_addr,
    output logic [7:0]    prog_data,
    output logic [AW-1:0] verify_addr
);

    localparam int MAXC = (ERASE_CYCLES > PROG_CYCLES) ? ERASE_CYCLES : PROG_CYCLES;
    localparam int CW   = $clog2(MAXC + 1);

    fstate_t       nxt;
    logic [CW-1:0] cnt;
    logic [AW-1:0] lat_addr;
    logic          vpp_q;
    logic          vpp_rise;
    logic          cmd_state;
    logic          cmd_accept;

    assign vpp_rise   = vpp_ok & ~vpp_q;
    assign cmd_state  = (state == ST_ARRAY) || (state == ST_IDENT) ||
                        (state == ST_ERASE_CHK) || (state == ST_PROG_CHK);
    assign cmd_accept = cmd_state && wr_end && !vpp_rise;

    function automatic fstate_t decode(input logic [7:0] code, input fstate_t cur,
                                       input logic supply);
        fstate_t r;
        r = cur;
        unique case (code)
            OP_READ:      r = ST_ARRAY;
            OP_IDENT:     r = ST_IDENT;
            OP_ERASE_CHK: r = ST_ERASE_CHK;
            OP_PROG_CHK:  r = ST_PROG_CHK;
            OP_RESET:     r = ST_RESET_ARM;
            OP_ERASE:     r = supply ? ST_ERASE_ARM : cur;
            OP_PROG:      r = supply ? ST_PROG_ARM : cur;
            default:      r = cur;
        endcase
        return r;
    endfunction

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_ERASE_RUN, ST_PROG_RUN: begin
                if (cnt == '0) nxt = ST_ARRAY;
            end
            ST_ERASE_ARM: begin
                if (vpp_rise) nxt = ST_ARRAY;
                else if (wr_end)
                    nxt = (bus_data == OP_ERASE && vpp_ok) ? ST_ERASE_RUN : ST_ARRAY;
            end
            ST_PROG_ARM: begin
                if (vpp_rise) nxt = ST_ARRAY;
                else if (wr_end) nxt = vpp_ok ? ST_PROG_RUN : ST_ARRAY;
            end
            ST_RESET_ARM: begin
                if (vpp_rise || wr_end) nxt = ST_ARRAY;
            end
            ST_ARRAY, ST_IDENT, ST_ERASE_CHK, ST_PROG_CHK: begin
                if (vpp_rise) nxt = ST_ARRAY;
                else if (wr_end) nxt = decode(bus_data, state, vpp_ok);
            end
            default: nxt = ST_ARRAY;
        endcase
    end

    // state register and latched operands
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_ARRAY;
            cnt         <= '0;
            lat_addr    <= '0;
            vpp_q       <= 1'b0;
            prog_addr   <= '0;
            prog_data   <= '0;
            verify_addr <= '0;
        end else begin
            state <= nxt;
            vpp_q <= vpp_ok;
            if (wr_start && !busy) lat_addr <= bus_addr;
            if (state == ST_PROG_ARM && nxt == ST_PROG_RUN) begin
                prog_addr <= lat_addr;
                prog_data <= bus_data;
                cnt       <= CW'(PROG_CYCLES - 1);
            end else if (state == ST_ERASE_ARM && nxt == ST_ERASE_RUN) begin
                cnt <= CW'(ERASE_CYCLES - 1);
            end else if (busy && cnt != '0) begin
                cnt <= cnt - 1'b1;
            end
            if (cmd_accept && bus_data == OP_ERASE_CHK) verify_addr <= lat_addr;
        end
    end

    // outputs
    always_comb begin
        busy     = (state == ST_ERASE_RUN) || (state == ST_PROG_RUN);
        erase_go = (state == ST_ERASE_RUN) && (cnt == '0);
        prog_go  = (state == ST_PROG_RUN) && (cnt == '0);
    end

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
    import flash_cmd_pkg::*;
#(
    parameter int AW           = 4,
    parameter int ERASE_CYCLES = 64,
    parameter int PROG_CYCLES  = 24,
    parameter int SYNC_STAGES  = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          vpp_ok,
    input  logic          ce_n,
    input  logic          we_n,
    input  logic          oe_n,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    din,
    output logic [7:0]    dout,
    output logic          busy
);

    logic          wr_start;
    logic          wr_end;
    fstate_t       state;
    logic          erase_go;
    logic          prog_go;
    logic [AW-1:0] prog_addr;
    logic [7:0]    prog_data;
    logic [AW-1:0] verify_addr;
    logic [AW-1:0] rd_addr;
    logic [7:0]    rd_data;
    logic [7:0]    rd_val;

    flash_wr_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .strobe_in (~ce_n & ~we_n),
        .wr_start  (wr_start),
        .wr_end    (wr_end)
    );

    flash_cmd_fsm #(
        .AW           (AW),
        .ERASE_CYCLES (ERASE_CYCLES),
        .PROG_CYCLES  (PROG_CYCLES)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .vpp_ok      (vpp_ok),
        .wr_start    (wr_start),
        .wr_end      (wr_end),
        .bus_addr    (addr),
        .bus_data    (din),
        .state       (state),
        .busy        (busy),
        .erase_go    (erase_go),
        .prog_go     (prog_go),
        .prog_addr   (prog_addr),
        .prog_data   (prog_data),
        .verify_addr (verify_addr)
    );

    flash_byte_array #(.AW(AW), .DW(8)) u_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .erase_go  (erase_go),
        .prog_go   (prog_go),
        .prog_addr (prog_addr),
        .prog_data (prog_data),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data)
    );

    always_comb begin
        unique case (state)
            ST_ERASE_CHK: rd_addr = verify_addr;
            ST_PROG_CHK:  rd_addr = prog_addr;
            default:      rd_addr = addr;
        endcase
    end

    always_comb begin
        if (state == ST_IDENT) begin
            if (addr == AW'(0))      rd_val = ID_MAKER;
            else if (addr == AW'(1)) rd_val = ID_PART;
            else                     rd_val = 8'h00;
        end else begin
            rd_val = rd_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout <= 8'h00;
        end else begin
            dout <= (!ce_n && !oe_n) ? rd_val : 8'h00;
        end
    end

endmodule

// File: rtl/flash_cmd_chk.sv
module flash_cmd_chk #(
    parameter int ERASE_CYCLES = 64,
    parameter int PROG_CYCLES  = 24
) (
    input logic       clk,
    input logic       rst_n,
    input logic       vpp_ok,
    input logic       ce_n,
    input logic       oe_n,
    input logic [7:0] dout,
    input logic       busy,
    input logic       erase_go,
    input logic       prog_go
);

    int run;

    always_ff @(posedge clk) begin
        if (!rst_n) run <= 0;
        else if (busy) run <= run + 1;
        else run <= 0;
    end

    a_r1_idle_dout: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_n || oe_n) |=> (dout == 8'h00));

    a_r12_start_needs_vpp: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(vpp_ok));

    a_r5_window_length: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run == ERASE_CYCLES || run == PROG_CYCLES));

    a_r5_erase_commit_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        erase_go |-> (busy && run == ERASE_CYCLES - 1));

    a_r7_prog_commit_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        prog_go |-> (busy && run == PROG_CYCLES - 1));

endmodule

bind flash_cmd_ctrl flash_cmd_chk #(
    .ERASE_CYCLES (ERASE_CYCLES),
    .PROG_CYCLES  (PROG_CYCLES)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .vpp_ok   (vpp_ok),
    .ce_n     (ce_n),
    .oe_n     (oe_n),
    .dout     (dout),
    .busy     (busy),
    .erase_go (erase_go),
    .prog_go  (prog_go)
);

// File: tb/sim_flash_cmd_ctrl.sv
`timescale 1ns/1ps
module sim_flash_cmd_ctrl;

    localparam int AW = 4;
    localparam int EC = 64;
    localparam int PC = 24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          vpp_ok = 1'b1;
    logic          ce_n = 1'b1;
    logic          we_n = 1'b1;
    logic          oe_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [7:0]    din = '0;
    logic [7:0]    dout;
    logic          busy;

    always #2.5 clk = ~clk;

    flash_cmd_ctrl #(.AW(AW), .ERASE_CYCLES(EC), .PROG_CYCLES(PC)) u0 (
        .clk(clk), .rst_n(rst_n), .vpp_ok(vpp_ok), .ce_n(ce_n), .we_n(we_n),
        .oe_n(oe_n), .addr(addr), .din(din), .dout(dout), .busy(busy)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // behavioural reference model
    int m_mem [16];
    int m_mode;   // 0 array, 1 ident, 2 erase arm, 3 erase verify, 4 prog arm, 5 prog verify, 6 reset arm
    int m_va;
    int m_pa;

    // busy window measurement
    int cur_len = 0;
    int last_len = 0;
    int windows = 0;
    int idle_cnt = 0;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // compared on every clock: busy length tracking and idle output
    always @(negedge clk) begin
        if (rst_n) begin
            if (busy) cur_len++;
            else if (cur_len > 0) begin
                last_len = cur_len;
                cur_len = 0;
                windows++;
            end
            if (ce_n || oe_n) idle_cnt++;
            else idle_cnt = 0;
            if (idle_cnt >= 2) chk("R1 idle dout", int'(dout), 0);
        end
    end

    function automatic int model_read(input int a);
        case (m_mode)
            1: return (a == 0) ? 'h89 : ((a == 1) ? 'hBD : 0);
            3: return m_mem[m_va];
            5: return m_mem[m_pa];
            default: return m_mem[a];
        endcase
    endfunction

    function automatic void model_write(input int a, input int d, input bit ign);
        if (ign) return;
        case (m_mode)
            2: begin
                if (d == 'h20 && vpp_ok) for (int i = 0; i < 16; i++) m_mem[i] = 'hFF;
                m_mode = 0;
            end
            4: begin
                if (vpp_ok) begin
                    m_mem[a] = m_mem[a] & d;
                    m_pa = a;
                end
                m_mode = 0;
            end
            6: m_mode = 0;
            default: begin
                case (d)
                    'h00: m_mode = 0;
                    'h90: m_mode = 1;
                    'hA0: begin m_mode = 3; m_va = a; end
                    'hC0: m_mode = 5;
                    'hFF: m_mode = 6;
                    'h20: if (vpp_ok) m_mode = 2;
                    'h40: if (vpp_ok) m_mode = 4;
                    default: ;
                endcase
            end
        endcase
    endfunction

    // address valid at strobe start, data valid at strobe end
    task automatic bus_write(input int a_start, input int d_end, input int a_late,
                             input int d_early, input bit ign);
        @(negedge clk);
        addr = AW'(a_start);
        din = 8'(d_early);
        ce_n = 1'b0;
        @(negedge clk);
        we_n = 1'b0;
        repeat (5) @(negedge clk);
        addr = AW'(a_late);
        din = 8'(d_end);
        repeat (2) @(negedge clk);
        we_n = 1'b1;
        repeat (5) @(negedge clk);
        ce_n = 1'b1;
        model_write(a_start, d_end, ign);
    endtask

    task automatic cmd(input int a, input int d);
        bus_write(a, d, a, d, 1'b0);
    endtask

    task automatic rd(input string req, input int a);
        @(negedge clk);
        addr = AW'(a);
        ce_n = 1'b0;
        oe_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(req, int'(dout), model_read(a));
        oe_n = 1'b1;
        ce_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic wait_idle();
        int t;
        t = 0;
        repeat (4) @(negedge clk);
        while (busy && t < 1000) begin
            @(negedge clk);
            t++;
        end
        repeat (2) @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) m_mem[i] = 'hFF;
        m_mode = 0; m_va = 0; m_pa = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 busy after reset", int'(busy), 0);
        chk("R1 dout after reset", int'(dout), 0);
        rd("R1 array after reset", 5);

        // identifier mode
        cmd(0, 'h90);
        rd("R3 maker id", 0);
        rd("R3 part id", 1);
        rd("R3 other addr", 2);
        cmd(0, 'h00);
        rd("R2 array read", 5);

        // program with address and data changing mid-strobe
        cmd(0, 'h40);
        bus_write(3, 'h5A, 9, 'h11, 1'b0);
        wait_idle();
        chk("R7 program window", last_len, PC);
        rd("R8 late address untouched", 9);
        rd("R8 start address programmed", 3);
        cmd(7, 'hC0);
        rd("R9 program verify", 0);
        cmd(0, 'h00);

        // AND merge
        cmd(0, 'h40);
        cmd(3, 'hF0);
        wait_idle();
        rd("R7 and merge", 3);

        // erase with wrong confirmation
        begin
            int w0;
            w0 = windows;
            cmd(0, 'h20);
            cmd(0, 'h00);
            wait_idle();
            chk("R4 no erase window", windows, w0);
            rd("R4 array unchanged", 3);
        end

        // writes during busy ignored
        cmd(0, 'h40);
        cmd(6, 'h0F);
        bus_write(0, 'h90, 0, 'h90, 1'b1);
        wait_idle();
        rd("R11 mode kept during busy", 0);
        rd("R11 programmed byte", 6);

        // erase verify before and after erase
        cmd(6, 'hA0);
        rd("R6 erase verify latched addr", 0);
        cmd(0, 'h00);
        cmd(0, 'h20);
        cmd(0, 'h20);
        wait_idle();
        chk("R5 erase window", last_len, EC);
        rd("R5 erased byte 3", 3);
        cmd(6, 'hA0);
        rd("R6 verify after erase", 1);
        cmd(0, 'h00);

        // supply absent
        begin
            int w0;
            w0 = windows;
            vpp_ok = 1'b0;
            cmd(0, 'h40);
            cmd(2, 'h00);
            cmd(0, 'h20);
            cmd(0, 'h20);
            wait_idle();
            chk("R12 no busy without supply", windows, w0);
            rd("R12 array unchanged", 2);
            cmd(0, 'h90);
            rd("R12 ident still works", 0);
            @(negedge clk);
            vpp_ok = 1'b1;
            m_mode = 0;
            repeat (3) @(negedge clk);
            rd("R1 supply rise returns to array", 0);
        end

        // double reset code
        cmd(0, 'h90);
        cmd(0, 'hFF);
        cmd(0, 'hFF);
        rd("R10 reset to array", 1);
        cmd(0, 'hC0);
        cmd(0, 'hFF);
        cmd(0, 'hFF);
        rd("R10 reset from verify", 4);

        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule